// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address and the base-register update for single word or byte load and store operations. It takes the already-read base register value, the already-read offset register value and the 32-bit operation word. From the operation word it takes the transfer class, the offset source, the indexing mode, the offset direction, the writeback request and the shift fields. The block does not read registers, perform the memory access, or handle halfword or multiple-register transfers.

The offset is one of two things: a 12-bit zero-extended immediate, or the offset register passed through a barrel shifter with an immediate amount. The shifter supports left logical, right logical, right arithmetic and rotate right. A shared adder or subtractor applies the offset to the base. Pre-indexed forms use the sum as the address and write it back only when asked. Post-indexed forms present the untouched base as the address and always write the sum back. A parameter chooses between outputs registered for one cycle, which is the default, and purely combinational outputs.

Top module: `ls_agu`

## Requirements
- R1: While reset is asserted and after it, until the first accepted operation, outValid, xferHit, wbEn, memAddr and wbValue are all zero.
- R2: An operation is a transfer only when inValid is 1 and instrWord[27:26] is 2'b01. For anything else, xferHit, wbEn, memAddr and wbValue are all zero.
- R3: When instrWord[25] is 0, the offset is instrWord[11:0] zero-extended to 32 bits.
- R4: When instrWord[25] is 1, the offset is offsetVal shifted by the amount in instrWord[11:7]. The kind of shift is set by instrWord[6:5]: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right. Rotate by 0 leaves the value unchanged.
- R5: A right-logical amount of 0 means a shift by 32, which gives zero. A right-arithmetic amount of 0 means a shift by 32, which gives 32 copies of offsetVal[31].
- R6: When instrWord[23] is 1, the offset is added to baseVal. When it is 0, the offset is subtracted. Both wrap modulo 2^32, and wbValue of a transfer is always this result.
- R7: When instrWord[24] is 1 (pre-indexed), memAddr is the base-plus-or-minus-offset result.
- R8: In pre-indexed transfers, wbEn equals instrWord[21].
- R9: When instrWord[24] is 0 (post-indexed), memAddr is the unmodified baseVal and wbEn is 1 regardless of instrWord[21].
- R10: With registered outputs, all outputs reflect the inputs of the previous clock edge, and outValid equals the previous cycle's inValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An operation is presented this cycle |
| instrWord | input | 32 | Operation word holding class, mode and offset fields |
| baseVal | input | 32 | Value of the base register |
| offsetVal | input | 32 | Value of the offset register |
| outValid | output | 1 | Outputs carry a result |
| xferHit | output | 1 | The result belongs to a single load/store |
| memAddr | output | 32 | Effective memory address |
| wbEn | output | 1 | Base register must be updated |
| wbValue | output | 32 | New base register value |

## Verification
The hardest case to reach is the zero shift amount on the right shifts. Random amounts hit zero only about once in 32 register-offset draws, and the arithmetic variant shows a difference only when the offset register's top bit is set. Directed vectors therefore force amount zero with both signs of the offset. They also cover post-indexing with the writeback bit clear, subtraction that wraps below zero, and a non-transfer class. Seeded random vectors then mix all of the mode bits, and some of them carry other operation classes and idle cycles.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;

  localparam int IMM_W   = 12;
  localparam int SHAMT_W = 5;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shiftKind_e;

  typedef struct packed {
    logic               launch;
    logic               xferHit;
    logic               useReg;
    logic               preIdx;
    logic               addUp;
    logic               wbReq;
    shiftKind_e         shKind;
    logic [SHAMT_W-1:0] shAmt;
    logic [IMM_W-1:0]   imm;
  } aguCtrl_t;

endpackage

// File: rtl/ls_agu_ctrl.sv
module ls_agu_ctrl
  import ls_agu_pkg::*;
(
  input  logic        inValid,
  input  logic [31:0] instrWord,
  output aguCtrl_t    ctrl
);

  localparam logic [1:0] XFER_CLASS = 2'b01;

  logic classMatch;

  always_comb begin
    classMatch   = (instrWord[27:26] == XFER_CLASS);
    ctrl.launch  = inValid;
    ctrl.xferHit = inValid & classMatch;
    ctrl.useReg  = instrWord[25];
    ctrl.preIdx  = instrWord[24];
    ctrl.addUp   = instrWord[23];
    ctrl.wbReq   = instrWord[21];
    ctrl.shKind  = shiftKind_e'(instrWord[6:5]);
    ctrl.shAmt   = instrWord[11:7];
    ctrl.imm     = instrWord[IMM_W-1:0];
  end

endmodule

// File: rtl/ls_agu_shift.sv
module ls_agu_shift
  import ls_agu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]  dataIn,
  input  shiftKind_e         shKind,
  input  logic [SHAMT_W-1:0] shAmt,
  output logic [DATA_W-1:0]  dataOut
);

  localparam int STAGES = SHAMT_W;

  logic [STAGES:0][DATA_W-1:0] stg;
  logic                        signBit;
  logic                        amtZero;

  assign signBit = dataIn[DATA_W-1];
  assign amtZero = (shAmt == '0);
  assign stg[0]  = dataIn;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [DATA_W-1:0] stepVal;

    always_comb begin
      unique case (shKind)
        SH_LSL:  stepVal = {stg[k][DATA_W-S-1:0], {S{1'b0}}};
        SH_LSR:  stepVal = {{S{1'b0}}, stg[k][DATA_W-1:S]};
        SH_ASR:  stepVal = {{S{signBit}}, stg[k][DATA_W-1:S]};
        default: stepVal = {stg[k][S-1:0], stg[k][DATA_W-1:S]};
      endcase
    end

    assign stg[k+1] = shAmt[k] ? stepVal : stg[k];
  end

  always_comb begin
    dataOut = stg[STAGES];
    if (amtZero) begin
      if (shKind == SH_LSR) dataOut = '0;
      else if (shKind == SH_ASR) dataOut = {DATA_W{signBit}};
    end
  end

endmodule

// File: rtl/ls_agu_datapath.sv
module ls_agu_datapath
  import ls_agu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  aguCtrl_t          ctrl,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] offsetVal,
  output logic              outValid,
  output logic              xferHit,
  output logic [DATA_W-1:0] memAddr,
  output logic              wbEn,
  output logic [DATA_W-1:0] wbValue
);

  logic [DATA_W-1:0] shiftOut;
  logic [DATA_W-1:0] offsetSel;
  logic [DATA_W-1:0] sumVal;
  logic [DATA_W-1:0] addrNext;
  logic [DATA_W-1:0] wbValNext;
  logic              wbEnNext;

  ls_agu_shift #(.DATA_W(DATA_W)) u_shift (
    .dataIn  (offsetVal),
    .shKind  (ctrl.shKind),
    .shAmt   (ctrl.shAmt),
    .dataOut (shiftOut)
  );

  always_comb begin
    offsetSel = ctrl.useReg ? shiftOut : {{(DATA_W-IMM_W){1'b0}}, ctrl.imm};
    sumVal    = ctrl.addUp ? (baseVal + offsetSel) : (baseVal - offsetSel);
    if (ctrl.xferHit) begin
      addrNext  = ctrl.preIdx ? sumVal : baseVal;
      wbEnNext  = ctrl.preIdx ? ctrl.wbReq : 1'b1;
      wbValNext = sumVal;
    end else begin
      addrNext  = '0;
      wbEnNext  = 1'b0;
      wbValNext = '0;
    end
  end

  // R5: full-width right shifts at amount zero
  p_lsr_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.useReg && ctrl.shKind == SH_LSR && ctrl.shAmt == '0) |-> (offsetSel == '0));
  p_asr_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.useReg && ctrl.shKind == SH_ASR && ctrl.shAmt == '0)
      |-> (offsetSel == {DATA_W{offsetVal[DATA_W-1]}}));
  // R3: immediate offset never exceeds its field
  p_imm_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.useReg |-> (offsetSel[DATA_W-1:IMM_W] == '0));

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        outValid <= 1'b0;
        xferHit  <= 1'b0;
        memAddr  <= '0;
        wbEn     <= 1'b0;
        wbValue  <= '0;
      end else begin
        outValid <= ctrl.launch;
        xferHit  <= ctrl.xferHit;
        memAddr  <= addrNext;
        wbEn     <= wbEnNext;
        wbValue  <= wbValNext;
      end
    end

    p_valid_hi_r10: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.launch |=> outValid);
    p_valid_lo_r10: assert property (@(posedge clk) disable iff (!rstN)
      !ctrl.launch |=> !outValid);
    p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
      !ctrl.xferHit |=> (!wbEn && memAddr == '0 && wbValue == '0));
    p_post_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.xferHit && !ctrl.preIdx) |=> (wbEn && memAddr == $past(baseVal)));
    p_pre_wb_r8: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.xferHit && ctrl.preIdx) |=> (wbEn == $past(ctrl.wbReq) && memAddr == wbValue));
    p_wb_needs_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
      wbEn |-> (xferHit && outValid));
  end else begin : g_comb
    always_comb begin
      outValid = ctrl.launch;
      xferHit  = ctrl.xferHit;
      memAddr  = addrNext;
      wbEn     = wbEnNext;
      wbValue  = wbValNext;
    end
  end

endmodule

// File: rtl/ls_agu.sv
module ls_agu
  import ls_agu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [31:0]       instrWord,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] offsetVal,
  output logic              outValid,
  output logic              xferHit,
  output logic [DATA_W-1:0] memAddr,
  output logic              wbEn,
  output logic [DATA_W-1:0] wbValue
);

  aguCtrl_t ctrl;

  ls_agu_ctrl u_ctrl (
    .inValid   (inValid),
    .instrWord (instrWord),
    .ctrl      (ctrl)
  );

  ls_agu_datapath #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .baseVal   (baseVal),
    .offsetVal (offsetVal),
    .outValid  (outValid),
    .xferHit   (xferHit),
    .memAddr   (memAddr),
    .wbEn      (wbEn),
    .wbValue   (wbValue)
  );

endmodule

// File: tb/sim_ls_agu.sv
`timescale 1ns/1ps
module sim_ls_agu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] baseVal = '0;
  logic [31:0] offsetVal = '0;
  logic        outValid, xferHit, wbEn;
  logic [31:0] memAddr, wbValue;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  ls_agu u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .baseVal(baseVal), .offsetVal(offsetVal), .outValid(outValid),
    .xferHit(xferHit), .memAddr(memAddr), .wbEn(wbEn), .wbValue(wbValue)
  );

  function automatic logic [31:0] refShift(input logic [31:0] v, input logic [1:0] kind,
                                           input logic [4:0] amt);
    logic signed [31:0] sv;
    logic [63:0]        dbl;
    int                 n;
    n   = int'(amt);
    sv  = v;
    dbl = {v, v};
    case (kind)
      2'b00: return v << n;
      2'b01: return (n == 0) ? 32'h0 : (v >> n);
      2'b10: return (n == 0) ? {32{v[31]}} : 32'(sv >>> n);
      default: return dbl[31:0] >> 0 == 0 ? 32'(dbl >> n) : 32'(dbl >> n);
    endcase
  endfunction

  function automatic logic [31:0] mkOp(input bit i, input bit p, input bit u,
                                       input bit w, input logic [11:0] low);
    return {4'hE, 2'b01, i, p, u, 1'b0, w, 1'b1, 4'd3, 4'd4, low};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic v, input logic [31:0] ins,
                       input logic [31:0] base, input logic [31:0] offr);
    logic        hit, eWb;
    logic [31:0] off, sum, eAddr, eWbv;
    inValid = v; instrWord = ins; baseVal = base; offsetVal = offr;
    hit   = v && (ins[27:26] == 2'b01);
    off   = ins[25] ? refShift(offr, ins[6:5], ins[11:7]) : {20'h0, ins[11:0]};
    sum   = ins[23] ? base + off : base - off;
    eAddr = !hit ? 32'h0 : (ins[24] ? sum : base);
    eWb   = hit && (ins[24] ? ins[21] : 1'b1);
    eWbv  = hit ? sum : 32'h0;
    @(posedge clk); #1;
    chk({tag, "/R10"}, "outValid", {31'h0, outValid}, {31'h0, v});
    chk({tag, "/R2"},  "xferHit",  {31'h0, xferHit},  {31'h0, hit});
    chk({tag, ins[24] ? "/R7" : "/R9"}, "memAddr", memAddr, eAddr);
    chk({tag, ins[24] ? "/R8" : "/R9"}, "wbEn", {31'h0, wbEn}, {31'h0, eWb});
    chk({tag, "/R6"}, "wbValue", wbValue, eWbv);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "outValid", {31'h0, outValid}, 32'h0);
    chk("R1", "xferHit",  {31'h0, xferHit}, 32'h0);
    chk("R1", "memAddr",  memAddr, 32'h0);
    chk("R1", "wbEn",     {31'h0, wbEn}, 32'h0);
    chk("R1", "wbValue",  wbValue, 32'h0);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1", "idle memAddr", memAddr, 32'h0);

    // R3: immediate offsets, pre with/without writeback
    apply("R3 pre imm wb", 1, mkOp(0, 1, 1, 1, 12'hFFF), 32'h0000_1000, 32'hDEAD_BEEF);
    apply("R3 pre imm nowb", 1, mkOp(0, 1, 1, 0, 12'h019), 32'h0000_0094, 32'h0);
    // R6: subtract wraps below zero
    apply("R6 wrap", 1, mkOp(0, 1, 0, 1, 12'h010), 32'h0000_0004, 32'h0);
    // R9: post-index ignores W
    apply("R9 post w0", 1, mkOp(0, 0, 1, 0, 12'h004), 32'h0000_2000, 32'h0);
    apply("R9 post w1", 1, mkOp(0, 0, 0, 1, 12'h004), 32'h0000_2000, 32'h0);
    // R4: each shift kind (amount 2 / 4)
    apply("R4 lsl", 1, mkOp(1, 1, 1, 0, {5'd2, 2'b00, 5'd0}), 32'h100, 32'h0000_0006);
    apply("R4 lsr", 1, mkOp(1, 1, 1, 0, {5'd4, 2'b01, 5'd0}), 32'h100, 32'h8000_00F0);
    apply("R4 asr", 1, mkOp(1, 1, 0, 0, {5'd4, 2'b10, 5'd0}), 32'h100, 32'h8000_00F0);
    apply("R4 ror", 1, mkOp(1, 0, 1, 0, {5'd4, 2'b11, 5'd0}), 32'h100, 32'h0000_00F3);
    apply("R4 ror0", 1, mkOp(1, 1, 1, 0, {5'd0, 2'b11, 5'd0}), 32'h100, 32'h1234_5678);
    // R5: amount zero on right shifts
    apply("R5 lsr0", 1, mkOp(1, 1, 1, 1, {5'd0, 2'b01, 5'd0}), 32'h500, 32'hFFFF_FFFF);
    apply("R5 asr0 neg", 1, mkOp(1, 1, 1, 1, {5'd0, 2'b10, 5'd0}), 32'h500, 32'h8000_0000);
    apply("R5 asr0 pos", 1, mkOp(1, 0, 1, 1, {5'd0, 2'b10, 5'd0}), 32'h500, 32'h7FFF_FFFF);
    // R2: other class and idle
    apply("R2 class10", 1, 32'hEA00_0003, 32'h800, 32'h4);
    apply("R2 idle", 0, mkOp(0, 1, 1, 1, 12'h8), 32'h800, 32'h4);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] ins;
      ins = $urandom();
      if (($urandom() % 8) != 0) ins[27:26] = 2'b01;
      apply("rand", (($urandom() % 10) != 0), ins, $urandom(), $urandom());
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule